// File: doc/BRIEF.md
# Selectable Reset Delay and Watchdog Supervisor

This block drives the system reset line of a supervisor. Three events start a reset. The first is the synchronous power-on reset. The second is a held manual reset request. The third is the expiry of an internal watchdog. After the last cycle in which any of these is present, the block keeps the reset output asserted for a hold time. A 2-bit code picks that hold time from a fixed, nonlinear set of values.

While reset is released, the watchdog counts clock cycles. Software restarts the count by pulsing a kick input. If the count reaches the period chosen by a second 2-bit code, the watchdog flags a one-cycle fault and starts a new reset hold. One watchdog code turns the watchdog off completely.

Times are given in milliseconds and converted to cycles through a ticks-per-millisecond parameter. A system that wants the usual factory behaviour ties the delay code to 01 (200 ms) and the watchdog code to 11 (off).

Top module: `rst_supervisor`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sys_rst_n` is 0 and `wd_fault` is 0 after that edge.
- R2: The hold lasts D = ms × TICKS_PER_MS cycles, where ms is 50, 200, 400 or 800 for `pup_sel` = 00, 01, 10 or 11. `sys_rst_n` rises after the D-th edge that follows the last edge with a reset cause present. The code in use is the one sampled at that last cause edge.
- R3: The watchdog period is P = ms × TICKS_PER_MS cycles, where ms is 1400, 200 or 25 for `wd_sel` = 00, 01 or 10. Expiry occurs at the P-th edge after the last restart, with no kick in between.
- R4: Watchdog code 11 disables the watchdog: `wd_fault` never rises and no reset starts from it.
- R5: A kick (`kick` high at a clock edge) restarts the watchdog count from zero. Expiry then comes P edges after the kick edge.
- R6: At expiry, `wd_fault` is high for exactly one cycle. `sys_rst_n` goes low in that same cycle and stays low for D cycles after it.
- R7: The watchdog does not count, and kicks have no effect, while `sys_rst_n` is low. A new period starts when reset is released.
- R8: A change of `wd_sel` takes effect only at the next kick or reset-driven restart. A period already running keeps the code it started with.
- R9: Manual reset `mr` (active high) forces `sys_rst_n` low in the same cycle, without waiting for a clock edge. The hold of R2 then applies from its release.
- R10: A kick at the edge on which the watchdog would expire wins: no fault occurs and a new period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| kick | input | 1 | Watchdog restart pulse, active high |
| pup_sel | input | 2 | Reset hold time code |
| wd_sel | input | 2 | Watchdog period code (11 = off) |
| mr | input | 1 | Manual reset request, active high |
| sys_rst_n | output | 1 | System reset output, active low |
| wd_fault | output | 1 | One-cycle pulse on watchdog expiry |

## Verification
The bench builds the block with TICKS_PER_MS = 2. With that value every hold time (100 to 1600 cycles) and every watchdog period (50 to 2800 cycles) is short enough to measure edge by edge. The bench therefore checks every code value and its exact cycle count, rather than scaled stand-ins. The short 25 ms period makes the corner cases cheap to reach: a kick landing on the expiry edge, a code change in the middle of a period, and kicks issued during a manual-reset hold.

// File: rtl/rst_sup_pkg.sv
// Package: code-to-time tables shared by the reset hold timer and watchdog.
// Assumes: codes are 2-bit; the watchdog value 0 means the watchdog is off.
package rst_sup_pkg;

    localparam logic [1:0] WD_OFF_CODE = 2'b11;
    localparam int unsigned HOLD_MS_MAX = 800;
    localparam int unsigned WD_MS_MAX   = 1400;

    // Reset hold time in milliseconds for a hold code.
    function automatic int unsigned hold_ms(input logic [1:0] code);
        case (code)
            2'b00:   return 50;
            2'b01:   return 200;
            2'b10:   return 400;
            default: return 800;
        endcase
    endfunction

    // Watchdog period in milliseconds for a watchdog code (0 = off).
    function automatic int unsigned wd_ms(input logic [1:0] code);
        case (code)
            2'b00:   return 1400;
            2'b01:   return 200;
            2'b10:   return 25;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/rst_hold_timer.sv
// Module: rst_hold_timer
// Keeps the reset active while a cause is present and for a code-selected
// number of cycles afterwards. The code is captured on every cause cycle, so
// the value present on the last cause cycle decides the length.
// Assumes: cause is synchronous to clk; TICKS_PER_MS >= 1.
module rst_hold_timer #(
    parameter int unsigned TICKS_PER_MS = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cause,
    input  logic [1:0] pup_sel,
    output logic       active
);
    import rst_sup_pkg::*;

    localparam int unsigned MAX_TICKS = HOLD_MS_MAX * TICKS_PER_MS;
    localparam int unsigned CW        = $clog2(MAX_TICKS + 1);

    logic [CW-1:0] cnt_q;
    logic [1:0]    code_q;
    logic [CW-1:0] lim;

    // Hold length in cycles for the captured code.
    always_comb lim = CW'(hold_ms(code_q) * TICKS_PER_MS);

    // Restart the hold on any cause; otherwise count down the hold.
    always_ff @(posedge clk) begin
        if (!rst_n || cause) begin
            active <= 1'b1;
            cnt_q  <= '0;
            code_q <= pup_sel;
        end else if (active) begin
            if (cnt_q == lim - CW'(1)) begin
                active <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    // R2
    hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q < lim));

    // R2
    hold_code_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !cause) |=> $stable(code_q));

endmodule

// File: rtl/wd_timer.sv
// Module: wd_timer
// Watchdog counter. A kick or an active hold restarts it and captures the
// period code. Expiry is flagged combinationally and as a registered pulse.
// Assumes: hold is high whenever the system reset is asserted.
module wd_timer #(
    parameter int unsigned TICKS_PER_MS = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    input  logic       kick,
    input  logic [1:0] wd_sel,
    output logic       expire,
    output logic       fault
);
    import rst_sup_pkg::*;

    localparam int unsigned MAX_TICKS = WD_MS_MAX * TICKS_PER_MS;
    localparam int unsigned CW        = $clog2(MAX_TICKS + 1);

    logic [CW-1:0] cnt_q;
    logic [1:0]    code_q;
    logic [CW-1:0] period;
    logic          enabled;

    // Period in cycles and enable for the captured code.
    always_comb begin
        period  = CW'(wd_ms(code_q) * TICKS_PER_MS);
        enabled = (code_q != WD_OFF_CODE);
    end

    // Expiry when the last cycle of the period is reached with no restart.
    always_comb expire = !hold && !kick && enabled && (cnt_q == period - CW'(1));

    // Restart, expire or advance the watchdog count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            code_q <= wd_sel;
            fault  <= 1'b0;
        end else begin
            fault <= expire;
            if (hold || kick) begin
                cnt_q  <= '0;
                code_q <= wd_sel;
            end else if (expire) begin
                cnt_q <= '0;
            end else if (enabled) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    // R6
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    // R7
    no_count_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt_q == '0) && !fault);

    // R4
    wd_off_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == WD_OFF_CODE && !hold && !kick) |=> ($stable(cnt_q) && !fault));

    // R5
    kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && !hold) |=> (cnt_q == '0) && !fault);

endmodule

// File: rtl/rst_supervisor.sv
// Module: rst_supervisor (top)
// Combines the reset hold timer and the watchdog. The reset output is low
// while the hold is active or manual reset is requested. Watchdog expiry and
// manual reset both restart the hold.
// Assumes: mr, kick and the selects are synchronous to clk.
module rst_supervisor #(
    parameter int unsigned TICKS_PER_MS = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kick,
    input  logic [1:0] pup_sel,
    input  logic [1:0] wd_sel,
    input  logic       mr,
    output logic       sys_rst_n,
    output logic       wd_fault
);
    logic hold_active;
    logic in_reset;
    logic wd_expire;
    logic hold_cause;

    // Reset causes after power-on: manual request or watchdog expiry.
    always_comb begin
        hold_cause = mr || wd_expire;
        in_reset   = hold_active || mr;
        sys_rst_n  = !in_reset;
    end

    rst_hold_timer #(.TICKS_PER_MS(TICKS_PER_MS)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause   (hold_cause),
        .pup_sel (pup_sel),
        .active  (hold_active)
    );

    wd_timer #(.TICKS_PER_MS(TICKS_PER_MS)) u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (in_reset),
        .kick    (kick),
        .wd_sel  (wd_sel),
        .expire  (wd_expire),
        .fault   (wd_fault)
    );

    // R1
    por_hold_chk: assert property (@(posedge clk)
        !rst_n |=> (!sys_rst_n && !wd_fault));

    // R6
    fault_starts_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_fault |-> hold_active);

    // R9
    mr_starts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mr |=> hold_active);

endmodule

// File: tb/sim_rst_supervisor.sv
module sim_rst_supervisor;
    localparam int unsigned TPM = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kick = 1'b0;
    logic [1:0] pup_sel = 2'b00;
    logic [1:0] wd_sel = 2'b10;
    logic       mr = 1'b0;
    logic       sys_rst_n;
    logic       wd_fault;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    rst_supervisor #(.TICKS_PER_MS(TPM)) u0 (
        .clk(clk), .rst_n(rst_n), .kick(kick), .pup_sel(pup_sel),
        .wd_sel(wd_sel), .mr(mr), .sys_rst_n(sys_rst_n), .wd_fault(wd_fault)
    );

    // {pup code, wd code, expected hold cycles, expected period (-1 = off)}
    localparam int VEC [5][4] = '{
        '{0, 2,  100,   50},
        '{1, 1,  400,  400},
        '{2, 0,  800, 2800},
        '{3, 3, 1600,   -1},
        '{1, 2,  400,   50}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic measure_rst(output int n);
        n = 0;
        while (!sys_rst_n && n < 5000) begin
            step(1);
            n++;
        end
    endtask

    task automatic measure_fault(output int n);
        n = 0;
        while (!wd_fault && n < 5000) begin
            step(1);
            n++;
        end
    endtask

    task automatic power_on(input logic [1:0] p, input logic [1:0] w);
        pup_sel = p;
        wd_sel  = w;
        rst_n   = 1'b0;
        step(2);
    endtask

    initial begin : watchdog
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        int n;
        int m;
        bit seen;
        @(negedge clk);

        // Table walk: every hold code and every watchdog code.
        for (int i = 0; i < 5; i++) begin
            power_on(2'(VEC[i][0]), 2'(VEC[i][1]));
            check(!sys_rst_n && !wd_fault, "R1 reset state", int'(sys_rst_n), 0);
            rst_n = 1'b1;
            measure_rst(n);
            check(n == VEC[i][2], "R2 hold length", n, VEC[i][2]);
            if (VEC[i][3] > 0) begin
                measure_fault(n);
                check(n == VEC[i][3], "R3 watchdog period", n, VEC[i][3]);
                check(!sys_rst_n, "R6 reset with fault", int'(sys_rst_n), 0);
                step(1);
                check(!wd_fault, "R6 one-cycle fault", int'(wd_fault), 0);
                measure_rst(m);
                check(m + 1 == VEC[i][2], "R6 hold after expiry", m + 1, VEC[i][2]);
            end else begin
                seen = 1'b0;
                for (int k = 0; k < 3000; k++) begin
                    step(1);
                    if (wd_fault || !sys_rst_n) seen = 1'b1;
                end
                check(!seen, "R4 watchdog off", int'(seen), 0);
            end
        end

        // R5: kick restarts the count (D=100, P=50).
        power_on(2'b00, 2'b10);
        rst_n = 1'b1;
        measure_rst(n);
        step(30);
        kick = 1'b1;
        step(1);
        kick = 1'b0;
        measure_fault(n);
        check(n == 50, "R5 period after kick", n, 50);
        measure_rst(n);
        check(n == 100, "R6 hold after expiry", n, 100);

        // R10: kick on the expiry edge wins.
        step(49);
        check(!wd_fault, "R10 before expiry edge", int'(wd_fault), 0);
        kick = 1'b1;
        step(1);
        check(!wd_fault && sys_rst_n, "R10 kick on expiry edge", int'(wd_fault), 0);
        kick = 1'b0;
        measure_fault(n);
        check(n == 50, "R10 new period after kick", n, 50);
        measure_rst(n);

        // R8: code change mid-period only applies at the next restart.
        wd_sel = 2'b01;
        measure_fault(n);
        check(n == 50, "R8 old code kept", n, 50);
        measure_rst(n);
        check(n == 100, "R2 hold code 00", n, 100);
        measure_fault(n);
        check(n == 400, "R8 new code after restart", n, 400);
        measure_rst(n);
        wd_sel = 2'b10;
        kick = 1'b1;
        step(1);
        kick = 1'b0;

        // R9: manual reset is immediate; R7: kicks during reset are ignored.
        pup_sel = 2'b10;
        mr = 1'b1;
        kick = 1'b1;
        #1;
        check(!sys_rst_n, "R9 immediate manual reset", int'(sys_rst_n), 0);
        step(5);
        mr = 1'b0;
        pup_sel = 2'b00;
        step(10);
        kick = 1'b0;
        measure_rst(n);
        check(n + 10 == 800, "R9 hold after manual release", n + 10, 800);
        measure_fault(n);
        check(n == 50, "R7 period restarts at release", n, 50);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule